// File: doc/BRIEF.md
# Dual-Port Synchronous SRAM with Selectable Read Pipelining

This block is a true dual-port static RAM with two independent ports, called left and right. Each port has its own clock, reset, address, read/write control, chip selects, byte disables, write data, read data and an output enable. Each word is 18 bits wide and holds two 9-bit lanes: the upper lane is bits [17:9] and the lower lane is bits [8:0]. The default depth is 4K words (`ADDR_W` = 12). Setting `ADDR_W` = 13 gives the 8K-word variant.

All synchronous inputs are taken on the rising edge of the port's own clock. A new address is loaded on every edge, so accesses may jump anywhere. A per-port mode input chooses how read data leaves the port:
- Flow-through (mode low): data appears in the cycle right after the sampling edge.
- Pipelined (mode high): data appears one cycle later, through an extra output register.

The output enable and the mode input act without a clock. The data pins are modelled as per-lane valid flags: a lane that is off drives zero.

Both ports may work at the same time on any addresses. When both ports write one address on the same edge, the left port's data is kept for every lane that both ports enable. That rule is only meaningful when both ports run on a common clock.

Top module: `dpsram_dual`

## Requirements
- R1: A write stores only the lanes whose byte-disable bit is low (bit 1 = upper lane [17:9], bit 0 = lower lane [8:0]); the other lane of that word keeps its old value.
- R2: A port is selected only when `*_sel_n` is 0 and `*_sel` is 1; a write issued while deselected changes no stored word.
- R3: In flow-through mode (`*_pipe` = 0), a read sampled at edge k shows its data and valid flags from edge k until edge k+1.
- R4: In pipelined mode (`*_pipe` = 1), a read sampled at edge k shows its data from edge k+1 until edge k+2, one cycle later than in flow-through mode.
- R5: The mode of each port is independent of the other port.
- R6: A write, or a cycle in which the port is deselected, produces no valid lane in the output cycle that matches it.
- R7: A lane whose byte-disable bit is 1 at the read sampling edge is not valid in the matching output cycle, and its data bits are 0.
- R8: With `*_oe_n` = 1, both valid flags and all data bits of that port are 0 at once, without waiting for a clock edge.
- R9: Reads to addresses in any order return the last data written to each address.
- R10: A word written by one port can be read by the other port in any later cycle.
- R11: When both ports write the same address on the same edge, each lane that both ports enable takes the left port's data, and a lane enabled only by the right port takes the right port's data.
- R12: While reset is asserted, and in the first cycle after reset is released, no valid flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_rst_n | input | 1 | Left port reset, active low |
| l_pipe | input | 1 | Left read mode: 0 flow-through, 1 pipelined (no clock needed) |
| l_oe_n | input | 1 | Left output enable, active low (no clock needed) |
| l_sel_n | input | 1 | Left chip select, active low |
| l_sel | input | 1 | Left chip select, active high |
| l_write | input | 1 | Left access type: 1 write, 0 read |
| l_byte_off | input | 2 | Left lane disables, bit 1 upper, bit 0 lower |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 18 | Left write data |
| l_rdata | output | 18 | Left read data, 0 in lanes that are not valid |
| l_valid | output | 2 | Left per-lane output valid |
| r_clk | input | 1 | Right port clock |
| r_rst_n | input | 1 | Right port reset, active low |
| r_pipe | input | 1 | Right read mode: 0 flow-through, 1 pipelined (no clock needed) |
| r_oe_n | input | 1 | Right output enable, active low (no clock needed) |
| r_sel_n | input | 1 | Right chip select, active low |
| r_sel | input | 1 | Right chip select, active high |
| r_write | input | 1 | Right access type: 1 write, 0 read |
| r_byte_off | input | 2 | Right lane disables, bit 1 upper, bit 0 lower |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 18 | Right write data |
| r_rdata | output | 18 | Right read data, 0 in lanes that are not valid |
| r_valid | output | 2 | Right per-lane output valid |

## Verification
A corrupted lane-ownership tag has a specific signature. A word still reads back correctly on its own port after a write, but shows stale data from the other port's copy on the very next read of that address. The cross-port and collision reads are placed to expose that within one cycle.

A stuck or mis-timed output stage shows up as valid flags one cycle early or late against the edge that sampled the read. Pipelined reads are therefore checked both in the cycle they must still be empty and in the cycle they must carry data.

A lane mask error shows either as a neighbouring lane that changed after a one-lane write, or as nonzero data in a lane flagged invalid. Both appear on the first read of the word.

// File: rtl/dpsram_pkg.sv
`timescale 1ns/1ps
package dpsram_pkg;
    // lanes per word and bits per lane
    localparam int unsigned LANES  = 2;
    localparam int unsigned LANE_W = 9;
    localparam int unsigned WORD_W = LANES * LANE_W;
    // lane index positions (upper lane holds the high bits)
    localparam int unsigned LANE_UP = 1;
    localparam int unsigned LANE_LO = 0;
    // read port slots on each storage bank
    localparam int unsigned RD_SLOTS = 3;
    localparam int unsigned SLOT_L   = 0;
    localparam int unsigned SLOT_R   = 1;
    localparam int unsigned SLOT_TAG = 2;
endpackage

// File: rtl/dpsram_bank.sv
`timescale 1ns/1ps
// One port's copy of the array: written only from its own clock, read
// combinationally through N_RD address slots. Each lane also keeps a tag bit
// used to decide which copy holds the newest data for that lane.
module dpsram_bank
    import dpsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned N_RD   = RD_SLOTS
) (
    input  logic                               clk,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [LANES-1:0]                   wr_lanes,
    input  logic [WORD_W-1:0]                  wr_data,
    input  logic [LANES-1:0]                   wr_tag,
    input  logic [N_RD-1:0][ADDR_W-1:0]        rd_addr,
    output logic [N_RD-1:0][WORD_W-1:0]        rd_data,
    output logic [N_RD-1:0][LANES-1:0]         rd_tag
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic              tag   [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
                store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
                tag[wr_addr]   <= wr_tag[g];
            end
        end

        for (genvar p = 0; p < N_RD; p++) begin : g_rd
            assign rd_data[p][g*LANE_W +: LANE_W] = store[rd_addr[p]];
            assign rd_tag[p][g]                   = tag[rd_addr[p]];
        end
    end
endmodule

// File: rtl/dpsram_port.sv
`timescale 1ns/1ps
// Per-port logic: input registers, optional output pipeline stage,
// mode and output-enable gating of the per-lane valid flags.
module dpsram_port
    import dpsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pipe_mode,
    input  logic                oe_n,
    input  logic                sel_n,
    input  logic                sel,
    input  logic                write,
    input  logic [LANES-1:0]    byte_off,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    // write request toward the storage banks
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [LANES-1:0]    wr_lanes,
    output logic [WORD_W-1:0]   wr_data,
    // registered read address and the resolved word it returns
    output logic [ADDR_W-1:0]   look_addr,
    input  logic [WORD_W-1:0]   look_word,
    // port outputs
    output logic [WORD_W-1:0]   dout,
    output logic [LANES-1:0]    dvalid
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  live;
        logic [LANES-1:0]  pipe_live;
        logic [WORD_W-1:0] pipe_word;
    } port_state_t;

    port_state_t st_d, st_q;
    logic               picked;
    logic [WORD_W-1:0]  flow_word;
    logic [WORD_W-1:0]  src_word;
    logic [LANES-1:0]   src_live;

    assign picked = !sel_n && sel;

    // write path uses the inputs present at the sampling edge
    assign wr_en    = picked && write;
    assign wr_addr  = addr;
    assign wr_lanes = ~byte_off;
    assign wr_data  = wdata;

    assign look_addr = st_q.addr;

    always_comb begin
        for (int g = 0; g < LANES; g++) begin
            flow_word[g*LANE_W +: LANE_W] = look_word[g*LANE_W +: LANE_W]
                                          & {LANE_W{st_q.live[g]}};
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.addr      = addr;
        st_d.live      = (picked && !write) ? ~byte_off : '0;
        st_d.pipe_live = st_q.live;
        st_d.pipe_word = flow_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_live = pipe_mode ? st_q.pipe_live : st_q.live;
    assign src_word = pipe_mode ? st_q.pipe_word : flow_word;
    assign dvalid   = src_live & {LANES{!oe_n}};

    always_comb begin
        for (int g = 0; g < LANES; g++) begin
            dout[g*LANE_W +: LANE_W] = src_word[g*LANE_W +: LANE_W]
                                     & {LANE_W{dvalid[g]}};
        end
    end
endmodule

// File: rtl/dpsram_dual.sv
`timescale 1ns/1ps
module dpsram_dual
    import dpsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic                l_clk,
    input  logic                l_rst_n,
    input  logic                l_pipe,
    input  logic                l_oe_n,
    input  logic                l_sel_n,
    input  logic                l_sel,
    input  logic                l_write,
    input  logic [LANES-1:0]    l_byte_off,
    input  logic [ADDR_W-1:0]   l_addr,
    input  logic [WORD_W-1:0]   l_wdata,
    output logic [WORD_W-1:0]   l_rdata,
    output logic [LANES-1:0]    l_valid,
    input  logic                r_clk,
    input  logic                r_rst_n,
    input  logic                r_pipe,
    input  logic                r_oe_n,
    input  logic                r_sel_n,
    input  logic                r_sel,
    input  logic                r_write,
    input  logic [LANES-1:0]    r_byte_off,
    input  logic [ADDR_W-1:0]   r_addr,
    input  logic [WORD_W-1:0]   r_wdata,
    output logic [WORD_W-1:0]   r_rdata,
    output logic [LANES-1:0]    r_valid
);
    localparam int unsigned PORTS = 2;

    logic                l_wr_en, r_wr_en;
    logic [ADDR_W-1:0]   l_wr_addr, r_wr_addr;
    logic [LANES-1:0]    l_wr_lanes, r_wr_lanes, r_lanes_eff;
    logic [WORD_W-1:0]   l_wr_data, r_wr_data;
    logic [ADDR_W-1:0]   l_look_addr, r_look_addr;
    logic [LANES-1:0]    l_tag_new, r_tag_new;
    logic                same_spot;

    logic [RD_SLOTS-1:0][ADDR_W-1:0] bl_rd_addr, br_rd_addr;
    logic [RD_SLOTS-1:0][WORD_W-1:0] bl_rd_data, br_rd_data;
    logic [RD_SLOTS-1:0][LANES-1:0]  bl_rd_tag,  br_rd_tag;
    logic [PORTS-1:0][WORD_W-1:0]    resolved;

    dpsram_port #(.ADDR_W(ADDR_W)) u_port_l (
        .clk       (l_clk),
        .rst_n     (l_rst_n),
        .pipe_mode (l_pipe),
        .oe_n      (l_oe_n),
        .sel_n     (l_sel_n),
        .sel       (l_sel),
        .write     (l_write),
        .byte_off  (l_byte_off),
        .addr      (l_addr),
        .wdata     (l_wdata),
        .wr_en     (l_wr_en),
        .wr_addr   (l_wr_addr),
        .wr_lanes  (l_wr_lanes),
        .wr_data   (l_wr_data),
        .look_addr (l_look_addr),
        .look_word (resolved[SLOT_L]),
        .dout      (l_rdata),
        .dvalid    (l_valid)
    );

    dpsram_port #(.ADDR_W(ADDR_W)) u_port_r (
        .clk       (r_clk),
        .rst_n     (r_rst_n),
        .pipe_mode (r_pipe),
        .oe_n      (r_oe_n),
        .sel_n     (r_sel_n),
        .sel       (r_sel),
        .write     (r_write),
        .byte_off  (r_byte_off),
        .addr      (r_addr),
        .wdata     (r_wdata),
        .wr_en     (r_wr_en),
        .wr_addr   (r_wr_addr),
        .wr_lanes  (r_wr_lanes),
        .wr_data   (r_wr_data),
        .look_addr (r_look_addr),
        .look_word (resolved[SLOT_R]),
        .dout      (r_rdata),
        .dvalid    (r_valid)
    );

    // Left-priority collision: right drops the lanes left writes at the same spot
    assign same_spot   = l_wr_en && r_wr_en && (l_wr_addr == r_wr_addr);
    assign r_lanes_eff = r_wr_lanes & ~(same_spot ? l_wr_lanes : '0);

    // Tag rule: left copies the right tag (xor 0), right stores the
    // inverse of the left tag (xor 1); xor of both tags names the owner.
    assign l_tag_new = br_rd_tag[SLOT_TAG];
    assign r_tag_new = ~bl_rd_tag[SLOT_TAG];

    assign bl_rd_addr = {r_wr_addr, r_look_addr, l_look_addr};
    assign br_rd_addr = {l_wr_addr, r_look_addr, l_look_addr};

    dpsram_bank #(.ADDR_W(ADDR_W), .N_RD(RD_SLOTS)) u_bank_l (
        .clk      (l_clk),
        .wr_en    (l_wr_en),
        .wr_addr  (l_wr_addr),
        .wr_lanes (l_wr_lanes),
        .wr_data  (l_wr_data),
        .wr_tag   (l_tag_new),
        .rd_addr  (bl_rd_addr),
        .rd_data  (bl_rd_data),
        .rd_tag   (bl_rd_tag)
    );

    dpsram_bank #(.ADDR_W(ADDR_W), .N_RD(RD_SLOTS)) u_bank_r (
        .clk      (r_clk),
        .wr_en    (r_wr_en),
        .wr_addr  (r_wr_addr),
        .wr_lanes (r_lanes_eff),
        .wr_data  (r_wr_data),
        .wr_tag   (r_tag_new),
        .rd_addr  (br_rd_addr),
        .rd_data  (br_rd_data),
        .rd_tag   (br_rd_tag)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_pick
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign resolved[p][g*LANE_W +: LANE_W] =
                (bl_rd_tag[p][g] ^ br_rd_tag[p][g])
                    ? br_rd_data[p][g*LANE_W +: LANE_W]
                    : bl_rd_data[p][g*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/dpsram_dual_chk.sv
`timescale 1ns/1ps
module dpsram_dual_chk
    import dpsram_pkg::*;
(
    input logic              l_clk,
    input logic              l_rst_n,
    input logic              l_pipe,
    input logic              l_oe_n,
    input logic              l_sel_n,
    input logic              l_sel,
    input logic              l_write,
    input logic [LANES-1:0]  l_byte_off,
    input logic [WORD_W-1:0] l_rdata,
    input logic [LANES-1:0]  l_valid,
    input logic              r_clk,
    input logic              r_rst_n,
    input logic              r_pipe,
    input logic              r_oe_n,
    input logic              r_sel_n,
    input logic              r_sel,
    input logic              r_write,
    input logic [LANES-1:0]  r_byte_off,
    input logic [WORD_W-1:0] r_rdata,
    input logic [LANES-1:0]  r_valid
);
    // R8
    l_oe_off_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        l_oe_n |-> (l_valid == '0));
    // R8
    r_oe_off_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        r_oe_n |-> (r_valid == '0));

    // R7
    l_zero_lane_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        (l_valid[LANE_UP] || l_rdata[WORD_W-1:LANE_W] == '0) &&
        (l_valid[LANE_LO] || l_rdata[LANE_W-1:0] == '0));
    // R7
    r_zero_lane_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        (r_valid[LANE_UP] || r_rdata[WORD_W-1:LANE_W] == '0) &&
        (r_valid[LANE_LO] || r_rdata[LANE_W-1:0] == '0));

    // R6
    l_no_data_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        (!l_pipe && (l_write || l_sel_n || !l_sel)) |=> (l_pipe || l_valid == '0));
    // R6
    r_no_data_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        (!r_pipe && (r_write || r_sel_n || !r_sel)) |=> (r_pipe || r_valid == '0));

    // R3
    l_flow_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        (!l_pipe && !l_sel_n && l_sel && !l_write && l_byte_off == '0)
        |=> (l_pipe || l_oe_n || l_valid == '1));
    // R3
    r_flow_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        (!r_pipe && !r_sel_n && r_sel && !r_write && r_byte_off == '0)
        |=> (r_pipe || r_oe_n || r_valid == '1));

    // R4
    l_pipe_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        (l_pipe && !l_sel_n && l_sel && !l_write && l_byte_off == '0)
        |=> ##1 (!l_pipe || l_oe_n || l_valid == '1));
    // R4
    r_pipe_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        (r_pipe && !r_sel_n && r_sel && !r_write && r_byte_off == '0)
        |=> ##1 (!r_pipe || r_oe_n || r_valid == '1));
endmodule

bind dpsram_dual dpsram_dual_chk u_chk (.*);

// File: tb/dpsram_dual_bench.sv
`timescale 1ns/1ps
module dpsram_dual_bench;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n;
    always #2.5 clk = ~clk;

    logic        l_pipe, l_oe_n, l_sel_n, l_sel, l_write;
    logic [1:0]  l_byte_off;
    logic [AW-1:0] l_addr;
    logic [17:0] l_wdata, l_rdata;
    logic [1:0]  l_valid;
    logic        r_pipe, r_oe_n, r_sel_n, r_sel, r_write;
    logic [1:0]  r_byte_off;
    logic [AW-1:0] r_addr;
    logic [17:0] r_wdata, r_rdata;
    logic [1:0]  r_valid;

    dpsram_dual #(.ADDR_W(AW)) u_dpsram_dual (
        .l_clk(clk), .l_rst_n(rst_n), .l_pipe(l_pipe), .l_oe_n(l_oe_n),
        .l_sel_n(l_sel_n), .l_sel(l_sel), .l_write(l_write),
        .l_byte_off(l_byte_off), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_valid(l_valid),
        .r_clk(clk), .r_rst_n(rst_n), .r_pipe(r_pipe), .r_oe_n(r_oe_n),
        .r_sel_n(r_sel_n), .r_sel(r_sel), .r_write(r_write),
        .r_byte_off(r_byte_off), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_valid(r_valid)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [17:0] ref_mem [1 << AW];

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [17:0] merge(logic [17:0] old, logic [17:0] nw, logic [1:0] off);
        merge = { off[1] ? old[17:9] : nw[17:9], off[0] ? old[8:0] : nw[8:0] };
    endfunction

    function automatic logic [17:0] masked(logic [17:0] w, logic [1:0] v);
        masked = { w[17:9] & {9{v[1]}}, w[8:0] & {9{v[0]}} };
    endfunction

    task automatic l_go(bit wr, logic [AW-1:0] a, logic [17:0] d, logic [1:0] off);
        l_sel_n = 1'b0; l_sel = 1'b1; l_write = wr; l_addr = a; l_wdata = d; l_byte_off = off;
    endtask
    task automatic r_go(bit wr, logic [AW-1:0] a, logic [17:0] d, logic [1:0] off);
        r_sel_n = 1'b0; r_sel = 1'b1; r_write = wr; r_addr = a; r_wdata = d; r_byte_off = off;
    endtask
    task automatic idle_both();
        l_sel_n = 1'b1; l_write = 1'b0; l_byte_off = 2'b00;
        r_sel_n = 1'b1; r_write = 1'b0; r_byte_off = 2'b00;
    endtask

    task automatic l_expect(logic [1:0] ev, logic [17:0] ed, string tag);
        chk(l_valid == ev && l_rdata == ed, tag, {12'h0, l_valid, l_rdata}, {12'h0, ev, ed});
    endtask
    task automatic r_expect(logic [1:0] ev, logic [17:0] ed, string tag);
        chk(r_valid == ev && r_rdata == ed, tag, {12'h0, r_valid, r_rdata}, {12'h0, ev, ed});
    endtask

    // R12: reset state and first cycle after release
    task automatic t_reset();
        rst_n = 1'b0;
        l_pipe = 0; r_pipe = 0; l_oe_n = 0; r_oe_n = 0; l_sel = 1; r_sel = 1;
        l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
        idle_both();
        repeat (4) tick();
        l_expect(2'b00, 18'h0, "R12 left in reset");
        r_expect(2'b00, 18'h0, "R12 right in reset");
        rst_n = 1'b1;
        tick();
        l_expect(2'b00, 18'h0, "R12 left after release");
        r_expect(2'b00, 18'h0, "R12 right after release");
    endtask

    // R9 R10 R3 R6: scattered writes from both ports, cross reads
    task automatic t_fill();
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a, b;
            logic [17:0] da, db;
            a  = AW'((i * 613 + 29) % (1 << AW));
            b  = AW'((i * 613 + 1301) % (1 << AW));
            da = 18'(32'h4C1D + i * 32'h7E35);
            db = 18'(32'h2B07 + i * 32'h5A93);
            l_go(1, a, da, 2'b00);
            r_go(1, b, db, 2'b00);
            ref_mem[a] = da;
            ref_mem[b] = db;
            tick();
            l_expect(2'b00, 18'h0, "R6 left write gives no data");
            r_expect(2'b00, 18'h0, "R6 right write gives no data");
        end
        for (int i = 7; i >= 0; i--) begin
            logic [AW-1:0] a, b;
            a = AW'((i * 613 + 29) % (1 << AW));
            b = AW'((i * 613 + 1301) % (1 << AW));
            l_go(0, b, 18'h0, 2'b00);
            r_go(0, a, 18'h0, 2'b00);
            tick();
            l_expect(2'b11, ref_mem[b], "R10 R9 R3 left reads right data");
            r_expect(2'b11, ref_mem[a], "R10 R9 R3 right reads left data");
        end
        idle_both();
        tick();
    endtask

    // R1 R7: single-lane writes and lane-disabled reads
    task automatic t_lanes();
        logic [AW-1:0] a;
        logic [17:0] e;
        a = AW'(12'h0A5);
        l_go(1, a, 18'h3FFFF, 2'b00); ref_mem[a] = 18'h3FFFF; tick();
        l_go(1, a, 18'h01234, 2'b01); ref_mem[a] = merge(ref_mem[a], 18'h01234, 2'b01); tick();
        e = ref_mem[a];
        l_go(0, a, 18'h0, 2'b00); tick();
        l_expect(2'b11, e, "R1 upper-only write keeps lower lane");
        r_go(1, a, 18'h2A0F0, 2'b10); ref_mem[a] = merge(ref_mem[a], 18'h2A0F0, 2'b10);
        idle_both(); r_go(1, a, 18'h2A0F0, 2'b10); tick();
        e = ref_mem[a];
        l_go(0, a, 18'h0, 2'b10);
        r_go(0, a, 18'h0, 2'b01);
        tick();
        l_expect(2'b01, masked(e, 2'b01), "R7 left upper lane disabled");
        r_expect(2'b10, masked(e, 2'b10), "R7 right lower lane disabled");
        idle_both(); tick();
    endtask

    // R2 R6: deselected accesses
    task automatic t_select();
        logic [AW-1:0] a;
        a = AW'(12'h0A5);
        l_go(1, a, 18'h15555, 2'b00); l_sel_n = 1'b1; tick();
        idle_both(); r_go(1, a, 18'h0AAAA, 2'b00); r_sel = 1'b0; tick();
        r_sel = 1'b1;
        l_go(0, a, 18'h0, 2'b00); l_sel = 1'b0;
        r_go(0, a, 18'h0, 2'b00);
        tick();
        l_expect(2'b00, 18'h0, "R6 deselected read gives no data");
        r_expect(2'b11, ref_mem[a], "R2 deselected writes left word unchanged");
        l_sel = 1'b1;
        idle_both(); tick();
    endtask

    // R4 R5: left pipelined, right flow-through, back-to-back reads
    task automatic t_pipe();
        logic [AW-1:0] x, y;
        x = AW'(12'd29); y = AW'((613 + 1301) % (1 << AW));
        l_pipe = 1'b1; r_pipe = 1'b0;
        idle_both(); tick();
        l_go(0, x, 18'h0, 2'b00);
        r_go(0, y, 18'h0, 2'b00);
        tick();
        l_expect(2'b00, 18'h0, "R4 pipelined read not yet out");
        r_expect(2'b11, ref_mem[y], "R5 right stays flow-through");
        l_go(0, y, 18'h0, 2'b00);
        r_sel_n = 1'b1;
        tick();
        l_expect(2'b11, ref_mem[x], "R4 pipelined first read one cycle later");
        r_expect(2'b00, 18'h0, "R5 right idle gives no data");
        idle_both(); tick();
        l_expect(2'b11, ref_mem[y], "R4 pipelined second read back to back");
        tick();
        l_expect(2'b00, 18'h0, "R4 pipeline drains");
        l_pipe = 1'b0;
    endtask

    // R8: asynchronous output enable
    task automatic t_oe();
        logic [AW-1:0] a;
        a = AW'(12'd29);
        l_go(0, a, 18'h0, 2'b00); tick();
        l_expect(2'b11, ref_mem[a], "R8 read before output disable");
        l_oe_n = 1'b1; #1;
        l_expect(2'b00, 18'h0, "R8 output enable off acts at once");
        l_oe_n = 1'b0; #1;
        l_expect(2'b11, ref_mem[a], "R8 output enable back on");
        idle_both(); tick();
    endtask

    // R11: same-address writes on the same edge
    task automatic t_collide();
        logic [AW-1:0] c;
        c = AW'(12'h7E1);
        l_go(1, c, 18'h2AAAA, 2'b00);
        r_go(1, c, 18'h15555, 2'b00);
        tick();
        idle_both(); r_go(0, c, 18'h0, 2'b00); tick();
        r_expect(2'b11, 18'h2AAAA, "R11 both lanes take left data");
        l_go(1, c, 18'h0F0F0, 2'b01);
        r_go(1, c, 18'h33CC3, 2'b00);
        tick();
        idle_both(); l_go(0, c, 18'h0, 2'b00); tick();
        l_expect(2'b11, {18'h0F0F0 >> 9, 9'(18'h33CC3)}, "R11 shared lane left, other lane right");
        idle_both(); tick();
    endtask

    initial begin
        t_reset();
        t_fill();
        t_lanes();
        t_select();
        t_pipe();
        t_oe();
        t_collide();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule